// File: doc/BRIEF.md
# BCD Calendar Counter with Cascaded Prescalers

This block keeps the time of day and the calendar date in packed BCD. The input clock is divided by two chained down-counters: a coarse prescaler whose terminal count advances a fine prescaler, and a fine prescaler whose terminal count produces the one-second tick. The fine prescaler's count is readable as a sub-second value that falls through the second and reloads when the second ends.

Seconds, minutes and hours run in 24-hour form. The date part tracks day of month, month, a two-digit year and a weekday, and applies real month lengths and leap Februaries. Software reaches the block through a word-addressed register port with a write strobe and a combinational read path. Time, date and sub-second reads normally come from shadow copies. These copies are refreshed one clock after every step of the fine prescaler, and a sync flag records each refresh. A control bit lets reads see the live counters instead.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the register port reads TIME (addr 0) = 0x000000, DATE (addr 1) = 0x002101 (day 01, month 01, year 00, weekday 1), SUBSEC (addr 2) = 0x00FF, STATUS (addr 3) = 0, PRESCALE (addr 4) = 0x007F00FF and CONTROL (addr 5) = 0.
- R2: PRESCALE holds the coarse divider A in bits 22:16 and the fine divider S in bits 14:0. The coarse counter steps the fine counter once every A+1 clocks. The fine counter falls from S to 0 and then reloads to S, and each reload is one second tick, so a tick comes every (A+1)*(S+1) clocks. SUBSEC bits 15:0 show the fine counter.
- R3: TIME is packed BCD: seconds units 3:0, seconds tens 6:4, minutes units 11:8, minutes tens 14:12, hours units 19:16, hours tens 21:20, and bit 22 reads 0. Each tick adds one second with BCD carries, and 23:59:59 becomes 00:00:00 and advances the date.
- R4: DATE is packed BCD: day units 3:0, day tens 5:4, month units 11:8, month tens 12, weekday 15:13, year units 19:16, year tens 23:20. Months 04, 06, 09 and 11 end after day 30, and the other months except 02 end after day 31. After the last day the date goes to day 01 of the next month.
- R5: A year divisible by 4 (00 included) gives February 29 days, otherwise 28. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R6: The weekday advances by one with each date advance, and 7 (Sunday) is followed by 1 (Monday).
- R7: One clock after each step of the fine counter, the shadow TIME, DATE and SUBSEC copies take the live values. Between refreshes the shadow copies hold.
- R8: STATUS bit 5 sets on each shadow refresh. Writing STATUS with bit 5 = 0 clears it, and writing 1 has no effect. A refresh in the same cycle as a clearing write leaves the flag set.
- R9: With CONTROL bit 5 (bypass) = 1, reads of addr 0..2 return the live counters. With bypass = 0 they return the shadow copies. CONTROL bit 6 (12-hour format) always reads 0.
- R10: A write to TIME or DATE loads the live counter directly, and it takes priority over a second tick or date advance in the same cycle.
- R11: A write to PRESCALE reloads both prescaler counters with the new A and S at that edge and restarts the second from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Word address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register, combinational |

## Verification
The flag-clearing write and the shadow refresh can land on the same clock edge. The bench provokes this by programming the smallest divider, so a refresh happens on every clock, and then writing 0 to the flag. Reading the flag set on the next sample proves that the set has priority. A software load of TIME or DATE can likewise meet a second tick or a midnight carry. The bench aligns such a write with a known tick edge after a prescaler restart, and checks that the written value survives and counting resumes from it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned REG_TIME   = 0;
  localparam int unsigned REG_DATE   = 1;
  localparam int unsigned REG_SUBSEC = 2;
  localparam int unsigned REG_STATUS = 3;
  localparam int unsigned REG_PRESC  = 4;
  localparam int unsigned REG_CTRL   = 5;

  localparam int unsigned SYNC_BIT   = 5;
  localparam int unsigned BYPASS_BIT = 5;
  localparam int unsigned COARSE_LSB = 16;

  localparam logic [23:0] DATE_RESET = 24'h002101;

  // Add one to a two-digit BCD byte (no wrap handling).
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year divisible by four.
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last BCD day of a BCD month.
  function automatic logic [5:0] month_days(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned A_W   = 7,
  parameter int unsigned S_W   = 15,
  parameter int unsigned SS_W  = 16,
  parameter int unsigned RST_A = 127,
  parameter int unsigned RST_S = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [A_W-1:0]  new_a,
  input  logic [S_W-1:0]  new_s,
  output logic [A_W-1:0]  cfg_a,
  output logic [S_W-1:0]  cfg_s,
  output logic            sub_step,
  output logic            sec_tick,
  output logic [SS_W-1:0] ss_count
);

  logic [A_W-1:0] a_cnt;
  logic [S_W-1:0] s_cnt;
  logic           a_tick;

  assign a_tick   = (a_cnt == '0);
  assign sub_step = a_tick && !load;
  assign sec_tick = sub_step && (s_cnt == '0);
  assign ss_count = SS_W'(s_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a <= A_W'(RST_A);
      cfg_s <= S_W'(RST_S);
      a_cnt <= A_W'(RST_A);
      s_cnt <= S_W'(RST_S);
    end else if (load) begin
      cfg_a <= new_a;
      cfg_s <= new_s;
      a_cnt <= new_a;
      s_cnt <= new_s;
    end else if (a_tick) begin
      a_cnt <= cfg_a;
      if (s_cnt == '0) s_cnt <= cfg_s;
      else             s_cnt <= s_cnt - 1'b1;
    end else begin
      a_cnt <= a_cnt - 1'b1;
    end
  end

  // R2: the fine counter never exceeds its reload value
  p_ss_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_cnt <= cfg_s);

  // R2: a second tick reloads the fine counter
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (s_cnt == cfg_s));

  // R2: a step away from zero decrements by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_step && s_cnt != '0) |=> (s_cnt == $past(s_cnt) - 1'b1));

  // R11: a prescaler write restarts both counters
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (a_cnt == $past(new_a) && s_cnt == $past(new_s)));

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [22:0] load_val,
  output logic [22:0] time_val,
  output logic        day_carry
);
  import rtc_cal_pkg::*;

  logic [6:0] sec_q, min_q, sec_n, min_n;
  logic [5:0] hr_q, hr_n;
  logic       sec_end, min_end, hr_end;
  logic       unused_load_bits;

  assign unused_load_bits = ^{load_val[22], load_val[15], load_val[7]};

  assign sec_end = (sec_q == 7'h59);
  assign min_end = (min_q == 7'h59);
  assign hr_end  = (hr_q  == 6'h23);

  assign sec_n = sec_end ? 7'h00 : 7'(bcd_inc8({1'b0, sec_q}));
  assign min_n = min_end ? 7'h00 : 7'(bcd_inc8({1'b0, min_q}));
  assign hr_n  = hr_end  ? 6'h00 : 6'(bcd_inc8({2'b00, hr_q}));

  assign day_carry = tick && !load && sec_end && min_end && hr_end;
  assign time_val  = {1'b0, hr_q, 1'b0, min_q, 1'b0, sec_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (load) begin
      sec_q <= load_val[6:0];
      min_q <= load_val[14:8];
      hr_q  <= load_val[21:16];
    end else if (tick) begin
      sec_q <= sec_n;
      if (sec_end) begin
        min_q <= min_n;
        if (min_end) hr_q <= hr_n;
      end
    end
  end

  // R3: midnight carry leaves the clock at 00:00:00
  p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (time_val == 23'h0));

  // R10: without a tick or a write the time holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(time_val));

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  input  logic        load,
  input  logic [23:0] load_val,
  output logic [23:0] date_val
);
  import rtc_cal_pkg::*;

  logic [5:0] day_q, last_day;
  logic [4:0] mon_q;
  logic [2:0] wd_q;
  logic [7:0] yr_q;
  logic       leap, day_end, mon_end, yr_end;
  logic       unused_load_bits;

  assign unused_load_bits = ^load_val[7:6];

  assign leap     = year_is_leap(yr_q);
  assign last_day = month_days(mon_q, leap);
  assign day_end  = (day_q == last_day);
  assign mon_end  = (mon_q == 5'h12);
  assign yr_end   = (yr_q == 8'h99);

  assign date_val = {yr_q, wd_q, mon_q, 2'b00, day_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q <= DATE_RESET[5:0];
      mon_q <= DATE_RESET[12:8];
      wd_q  <= DATE_RESET[15:13];
      yr_q  <= DATE_RESET[23:16];
    end else if (load) begin
      day_q <= load_val[5:0];
      mon_q <= load_val[12:8];
      wd_q  <= load_val[15:13];
      yr_q  <= load_val[23:16];
    end else if (advance) begin
      wd_q <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
      if (day_end) begin
        day_q <= 6'h01;
        mon_q <= mon_end ? 5'h01 : 5'(bcd_inc8({3'b000, mon_q}));
        if (mon_end) yr_q <= yr_end ? 8'h00 : bcd_inc8(yr_q);
      end else begin
        day_q <= 6'(bcd_inc8({2'b00, day_q}));
      end
    end
  end

  // R6: an advance never leaves weekday zero
  p_wday_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (date_val[15:13] != 3'd0));

  // R4: an advance never leaves day zero
  p_day_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (date_val[5:0] != 6'h00));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PRE_A_W = 7,
  parameter int unsigned PRE_S_W = 15,
  parameter int unsigned SS_W    = 16,
  parameter int unsigned RST_A   = 127,
  parameter int unsigned RST_S   = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import rtc_cal_pkg::*;

  localparam int unsigned A_HI = COARSE_LSB + PRE_A_W - 1;

  logic               wr_time, wr_date, wr_stat, wr_pre, wr_ctrl;
  logic [PRE_A_W-1:0] cfg_a;
  logic [PRE_S_W-1:0] cfg_s;
  logic               sub_step, sec_tick, day_carry;
  logic [SS_W-1:0]    live_ss, shd_ss;
  logic [22:0]        live_time, shd_time;
  logic [23:0]        live_date, shd_date;
  logic               refresh_q, sync_flag, bypass;
  logic               unused_wdata;

  assign unused_wdata = ^wdata;

  assign wr_time = wr_en && (addr == ADDR_W'(REG_TIME));
  assign wr_date = wr_en && (addr == ADDR_W'(REG_DATE));
  assign wr_stat = wr_en && (addr == ADDR_W'(REG_STATUS));
  assign wr_pre  = wr_en && (addr == ADDR_W'(REG_PRESC));
  assign wr_ctrl = wr_en && (addr == ADDR_W'(REG_CTRL));

  rtc_prescaler #(
    .A_W(PRE_A_W), .S_W(PRE_S_W), .SS_W(SS_W), .RST_A(RST_A), .RST_S(RST_S)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .load(wr_pre),
    .new_a(wdata[A_HI:COARSE_LSB]), .new_s(wdata[PRE_S_W-1:0]),
    .cfg_a(cfg_a), .cfg_s(cfg_s),
    .sub_step(sub_step), .sec_tick(sec_tick), .ss_count(live_ss)
  );

  rtc_time_counter u_time (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(wr_time),
    .load_val(wdata[22:0]), .time_val(live_time), .day_carry(day_carry)
  );

  rtc_date_counter u_date (
    .clk(clk), .rst_n(rst_n), .advance(day_carry), .load(wr_date),
    .load_val(wdata[23:0]), .date_val(live_date)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_q <= 1'b0;
      shd_time  <= '0;
      shd_date  <= DATE_RESET;
      shd_ss    <= SS_W'(RST_S);
      sync_flag <= 1'b0;
      bypass    <= 1'b0;
    end else begin
      refresh_q <= sub_step;
      if (refresh_q) begin
        shd_time <= live_time;
        shd_date <= live_date;
        shd_ss   <= live_ss;
      end
      if (refresh_q)                     sync_flag <= 1'b1;
      else if (wr_stat && !wdata[SYNC_BIT]) sync_flag <= 1'b0;
      if (wr_ctrl) bypass <= wdata[BYPASS_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_TIME):   rdata = DATA_W'(bypass ? live_time : shd_time);
      ADDR_W'(REG_DATE):   rdata = DATA_W'(bypass ? live_date : shd_date);
      ADDR_W'(REG_SUBSEC): rdata = DATA_W'(bypass ? live_ss : shd_ss);
      ADDR_W'(REG_STATUS): rdata[SYNC_BIT] = sync_flag;
      ADDR_W'(REG_PRESC): begin
        rdata[A_HI:COARSE_LSB] = cfg_a;
        rdata[PRE_S_W-1:0]     = cfg_s;
      end
      ADDR_W'(REG_CTRL):   rdata[BYPASS_BIT] = bypass;
      default:             rdata = '0;
    endcase
  end

  // R7: shadow copies move only on a refresh
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_q |=> ($stable(shd_time) && $stable(shd_date) && $stable(shd_ss)));

  // R8: a refresh always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_q |=> sync_flag);

  // R8: a clearing write without a refresh clears the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[SYNC_BIT] && !refresh_q) |=> !sync_flag);

endmodule

// File: tb/bcd_calendar_core_tb.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb;

  localparam logic [2:0] A_TIME = 3'd0, A_DATE = 3'd1, A_SS = 3'd2,
                         A_STAT = 3'd3, A_PRE = 3'd4, A_CTRL = 3'd5;
  localparam logic [31:0] FREEZE = 32'h007F7FFF;
  localparam logic [31:0] FAST   = 32'h00000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_calendar_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input string req, input string what,
                            input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  // Load time and date while frozen, then run k fast seconds (bypass on).
  task automatic cal_step(input string req, input logic [31:0] t, input logic [31:0] d,
                          input int k, input logic [31:0] et, input logic [31:0] ed);
    wr(A_PRE, FREEZE);
    wr(A_TIME, t);
    wr(A_DATE, d);
    wr(A_PRE, FAST);
    wait_cyc(2 * k);
    expect_reg(req, "time", A_TIME, et);
    expect_reg(req, "date", A_DATE, ed);
  endtask

  task automatic t_reset;
    expect_reg("R1", "time reset", A_TIME, 32'h0);
    expect_reg("R1", "date reset", A_DATE, 32'h00002101);
    expect_reg("R1", "subsec reset", A_SS, 32'h000000FF);
    expect_reg("R1", "status reset", A_STAT, 32'h0);
    expect_reg("R1", "prescale reset", A_PRE, 32'h007F00FF);
    expect_reg("R1", "control reset", A_CTRL, 32'h0);
  endtask

  task automatic t_prescaler;
    wr(A_PRE, FREEZE);
    wr(A_TIME, 32'h0);
    wr(A_PRE, 32'h00020003);
    expect_reg("R11", "subsec after restart", A_SS, 32'h3);
    expect_reg("R11", "prescale readback", A_PRE, 32'h00020003);
    wait_cyc(3);
    expect_reg("R2", "subsec after A+1 clocks", A_SS, 32'h2);
    wait_cyc(8);
    expect_reg("R2", "subsec at zero", A_SS, 32'h0);
    expect_reg("R2", "no tick before period", A_TIME, 32'h0);
    wait_cyc(1);
    expect_reg("R2", "subsec reloaded", A_SS, 32'h3);
    expect_reg("R2", "tick after 12 clocks", A_TIME, 32'h1);
    wait_cyc(12);
    expect_reg("R2", "second tick period", A_TIME, 32'h2);
  endtask

  task automatic t_rollover;
    cal_step("R3", 32'h00000959, 32'h00232130, 1, 32'h00001000, 32'h00232130);
    cal_step("R3", 32'h00095959, 32'h00232130, 1, 32'h00100000, 32'h00232130);
    cal_step("R3", 32'h00235958, 32'h0099F231, 1, 32'h00235959, 32'h0099F231);
    cal_step("R5", 32'h00235958, 32'h0099F231, 2, 32'h0, 32'h00002101);
  endtask

  task automatic t_months;
    cal_step("R4", 32'h00235959, 32'h00236430, 1, 32'h0, 32'h00238501);
    cal_step("R4", 32'h00235959, 32'h00232130, 1, 32'h0, 32'h00234131);
    cal_step("R6", 32'h00235959, 32'h0023E131, 1, 32'h0, 32'h00232201);
  endtask

  task automatic t_leap;
    cal_step("R5", 32'h00235959, 32'h00242228, 1, 32'h0, 32'h00244229);
    cal_step("R5", 32'h00235959, 32'h00244229, 1, 32'h0, 32'h00246301);
    cal_step("R5", 32'h00235959, 32'h00232228, 1, 32'h0, 32'h00234301);
    cal_step("R5", 32'h00235959, 32'h00002228, 1, 32'h0, 32'h00004229);
    cal_step("R5", 32'h00235959, 32'h00122228, 1, 32'h0, 32'h00124229);
  endtask

  task automatic t_write_vs_tick;
    wr(A_PRE, FREEZE);
    wr(A_TIME, 32'h00010000);
    wr(A_PRE, FAST);
    wr(A_TIME, 32'h00070707);
    expect_reg("R10", "time write beats tick", A_TIME, 32'h00070707);
    wait_cyc(2);
    expect_reg("R10", "count resumes from write", A_TIME, 32'h00070708);
    wr(A_PRE, FREEZE);
    wr(A_TIME, 32'h00235959);
    wr(A_DATE, 32'h00232130);
    wr(A_PRE, FAST);
    wr(A_DATE, 32'h00244229);
    expect_reg("R10", "date write beats carry", A_DATE, 32'h00244229);
    expect_reg("R10", "midnight still taken", A_TIME, 32'h0);
  endtask

  task automatic t_format;
    wr(A_CTRL, 32'h00000060);
    expect_reg("R9", "format bit held at 0", A_CTRL, 32'h00000020);
  endtask

  task automatic t_shadow;
    logic [31:0] old_t;
    wr(A_PRE, FREEZE);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h0);
    expect_reg("R8", "flag cleared", A_STAT, 32'h0);
    rd(A_TIME, old_t);
    wr(A_TIME, 32'h00120000);
    expect_reg("R9", "shadow not live", A_TIME, old_t);
    wr(A_PRE, 32'h00030001);
    wait_cyc(4);
    expect_reg("R7", "no refresh yet", A_STAT, 32'h0);
    expect_reg("R7", "shadow still old", A_TIME, old_t);
    wait_cyc(1);
    expect_reg("R8", "flag set by refresh", A_STAT, 32'h00000020);
    expect_reg("R7", "shadow time refreshed", A_TIME, 32'h00120000);
    expect_reg("R7", "shadow subsec refreshed", A_SS, 32'h0);
    wait_cyc(3);
    expect_reg("R7", "shadow lags tick", A_TIME, 32'h00120000);
    wait_cyc(1);
    expect_reg("R7", "shadow after tick", A_TIME, 32'h00120001);
    expect_reg("R7", "shadow subsec reload", A_SS, 32'h1);
  endtask

  task automatic t_flag;
    wr(A_PRE, FREEZE);
    wr(A_STAT, 32'h0);
    expect_reg("R8", "flag clear", A_STAT, 32'h0);
    wr(A_STAT, 32'h00000020);
    expect_reg("R8", "writing 1 ignored", A_STAT, 32'h0);
    wr(A_PRE, FAST);
    wr(A_STAT, 32'h0);
    expect_reg("R8", "refresh wins over clear", A_STAT, 32'h00000020);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset;
    wr(A_CTRL, 32'h00000020);
    t_prescaler;
    t_rollover;
    t_months;
    t_leap;
    t_write_vs_tick;
    t_format;
    t_shadow;
    t_flag;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule